// File: doc/BRIEF.md
# Streaming Load Line Buffer

This block sits beside a load path and serves non-temporal streaming loads that target write-combining memory without placing the data in any cache. When a streaming load to such a region misses, the block reads the whole aligned 64-byte line containing the address through a memory-side port. It keeps that line in a single internal buffer and returns only the requested 16-, 32- or 64-byte piece. Later streaming loads that ask for parts of the same line not yet handed out are answered from the buffer, one cycle after acceptance, with no memory traffic.

The buffer tracks which 16-byte chunks have been delivered. It discards its contents when the same chunk is requested again, when an ordinary load or a write touches the buffered line, when any access tagged as non-write-combining touches that line, or when the flush input is raised. The access that causes a discard is still serviced through memory; a streaming one refills the buffer with a fresh line. Requests whose address is not aligned to their size are refused with a general-protection fault. Requests use a valid/ready handshake, and only one memory transaction is in flight at a time.

Top module: `sllb_line_buf`

## Requirements
- R1: After reset the buffer holds no line, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A streaming load (`req_kind` = 1) with `req_wc` = 1 that misses issues exactly one memory read whose `mem_addr` is the address with its low 6 bits cleared, then returns the requested bytes of that line in `rsp_data` starting at bit 0 with `rsp_fault` = 0.
- R3: A streaming load with `req_wc` = 1 to chunks of the buffered line that have not been delivered is answered in the cycle after acceptance with the correct bytes and no memory request.
- R4: A streaming load with `req_wc` = 1 covering any already-delivered chunk of the buffered line discards the buffer and starts a new line read; the refilled buffer marks only the chunks of that access as delivered.
- R5: An ordinary load (`req_kind` = 0, or the reserved value 3) to the buffered line discards the buffer and is served through a memory read.
- R6: Any access with `req_wc` = 0 to the buffered line discards the buffer; a streaming load with `req_wc` = 0 is served through memory like an ordinary load and never fills the buffer.
- R7: A write (`req_kind` = 2) to the buffered line discards the buffer; the write goes to memory with `mem_we` = 1, the line address, `req_wdata` moved to the byte offset of the address, and `mem_be` set for exactly the written bytes.
- R8: A request whose address is not a multiple of its size returns `rsp_fault` = 1 with `rsp_data` all zero, makes no memory request and leaves the buffer unchanged.
- R9: `req_size` selects 16 bytes (0), 32 bytes (1) or 64 bytes (2); value 3 always faults. Response bytes above the access size are zero, and a 32- or 64-byte streaming access checks and marks every 16-byte chunk it covers.
- R10: Raising `flush` in any cycle empties the buffer; a flush during a line read still returns the data but the line is not kept.
- R11: While a memory transaction is outstanding `req_ready` is 0, and `mem_req_valid`, `mem_addr` stay steady until `mem_req_ready` accepts them.
- R12: Accesses to lines other than the buffered one leave the buffer and its delivered-chunk record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard the buffer contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0: 16 B, 1: 32 B, 2: 64 B, 3: invalid |
| req_kind | input | 2 | 0: load, 1: streaming load, 2: write, 3: load |
| req_wc | input | 1 | Region is write-combining |
| req_wdata | input | LINE_BYTES*8 | Write data, least significant byte first |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | General-protection fault |
| rsp_data | output | LINE_BYTES*8 | Load data, zero above the access size |
| mem_req_valid | output | 1 | Memory transaction request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_we | output | 1 | Transaction is a write |
| mem_wdata | output | LINE_BYTES*8 | Line-positioned write data |
| mem_be | output | LINE_BYTES | Byte enables for a write |
| mem_rvalid | input | 1 | Read data or write completion |
| mem_rdata | input | LINE_BYTES*8 | Full line of read data |

## Verification
The bench counts memory transactions around every request, so a design that refetched on a buffer hit, or served a re-read chunk from stale contents, shows up as a wrong transaction count rather than only wrong data. It goes after the delivered-chunk record: after a re-read refill only the re-read chunk may be marked, and a wide access that overlaps one delivered chunk must refetch, so a mask that was not reset or was only partly checked gives a hit where a fetch is due. It flushes in the middle of a line read, where a design that allocated anyway would serve the next chunk with no fetch, and it sends faulting and foreign-line requests between hits to show that they neither touch memory nor disturb the buffer.

// File: rtl/sllb_pkg.sv
package sllb_pkg;

    typedef enum logic [1:0] {
        K_LOAD   = 2'd0,
        K_STREAM = 2'd1,
        K_WRITE  = 2'd2,
        K_RSVD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

endpackage

// File: rtl/sllb_decode.sv
module sllb_decode #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int CHUNK_BYTES = 16,
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int CB_W    = $clog2(CHUNK_BYTES),
    localparam int NCHUNK  = LINE_BYTES / CHUNK_BYTES,
    localparam int CIDX_W  = $clog2(NCHUNK),
    localparam int TAG_W   = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            size,
    output logic                  misalign,
    output logic [NCHUNK-1:0]     chunk_mask,
    output logic [LINE_BYTES-1:0] byte_mask,
    output logic [TAG_W-1:0]      tag,
    output logic [OFF_W-1:0]      offset
);

    logic              too_big;
    logic [OFF_W:0]    nbytes;
    logic [CIDX_W:0]   lo;
    logic [CIDX_W:0]   hi;

    // Size codes above log2(chunks per line) describe an access wider than a line.
    always_comb begin
        too_big  = ({30'b0, size} > CIDX_W);
        nbytes   = too_big ? '0 : ((OFF_W+1)'(CHUNK_BYTES) << size);
        misalign = too_big || ((({1'b0, addr[OFF_W-1:0]}) & (nbytes - 1'b1)) != '0);
        tag      = addr[ADDR_W-1:OFF_W];
        offset   = addr[OFF_W-1:0];
        lo       = {1'b0, addr[OFF_W-1:CB_W]};
        hi       = lo + ((CIDX_W+1)'(1) << size);
        for (int i = 0; i < NCHUNK; i++) begin
            chunk_mask[i] = !too_big && ((CIDX_W+1)'(i) >= lo) && ((CIDX_W+1)'(i) < hi);
        end
    end

    // Byte enables follow the chunk coverage of the access.
    for (genvar j = 0; j < LINE_BYTES; j++) begin : g_be
        assign byte_mask[j] = chunk_mask[j / CHUNK_BYTES];
    end

endmodule

// File: rtl/sllb_extract.sv
module sllb_extract #(
    parameter int LINE_BYTES  = 64,
    parameter int CHUNK_BYTES = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size,
    output logic [LINE_W-1:0] data
);

    logic [LINE_W-1:0] shifted;
    logic [OFF_W:0]    nbytes;

    assign shifted = line >> {offset, 3'b000};
    assign nbytes  = (OFF_W+1)'(CHUNK_BYTES) << size;

    // Bytes past the access size are forced to zero.
    for (genvar j = 0; j < LINE_BYTES; j++) begin : g_byte
        assign data[j*8 +: 8] = ((OFF_W+1)'(j) < nbytes) ? shifted[j*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sllb_line_buf.sv
module sllb_line_buf
    import sllb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int CHUNK_BYTES = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int NCHUNK = LINE_BYTES / CHUNK_BYTES,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    input  logic [1:0]            req_kind,
    input  logic                  req_wc,
    input  logic [LINE_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic [LINE_W-1:0]     rsp_data,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_we,
    output logic [LINE_W-1:0]     mem_wdata,
    output logic [LINE_BYTES-1:0] mem_be,
    input  logic                  mem_rvalid,
    input  logic [LINE_W-1:0]     mem_rdata
);

    typedef struct packed {
        st_e                   state;
        logic                  buf_valid;
        logic [TAG_W-1:0]      buf_tag;
        logic [NCHUNK-1:0]     buf_mask;
        logic [LINE_W-1:0]     buf_data;
        logic [TAG_W-1:0]      cur_tag;
        logic                  cur_we;
        logic [LINE_W-1:0]     cur_wdata;
        logic [LINE_BYTES-1:0] cur_be;
        logic                  cur_alloc;
        logic [OFF_W-1:0]      cur_off;
        logic [1:0]            cur_size;
        logic [NCHUNK-1:0]     cur_mask;
        logic                  rsp_valid;
        logic                  rsp_fault;
        logic [LINE_W-1:0]     rsp_data;
    } regs_t;

    regs_t r_q, r_d;

    // ------------------------------------------------------------ decode
    logic                  dec_mis;
    logic [NCHUNK-1:0]     dec_cmask;
    logic [LINE_BYTES-1:0] dec_bmask;
    logic [TAG_W-1:0]      dec_tag;
    logic [OFF_W-1:0]      dec_off;

    sllb_decode #(
        .ADDR_W      (ADDR_W),
        .LINE_BYTES  (LINE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_decode (
        .addr       (req_addr),
        .size       (req_size),
        .misalign   (dec_mis),
        .chunk_mask (dec_cmask),
        .byte_mask  (dec_bmask),
        .tag        (dec_tag),
        .offset     (dec_off)
    );

    // ------------------------------------------------------------ data select
    // One extractor serves both the buffer (idle hits) and the returning line.
    logic              in_wait;
    logic [LINE_W-1:0] ext_line;
    logic [OFF_W-1:0]  ext_off;
    logic [1:0]        ext_size;
    logic [LINE_W-1:0] ext_data;

    assign in_wait  = (r_q.state == ST_WAIT);
    assign ext_line = in_wait ? mem_rdata  : r_q.buf_data;
    assign ext_off  = in_wait ? r_q.cur_off  : dec_off;
    assign ext_size = in_wait ? r_q.cur_size : req_size;

    sllb_extract #(
        .LINE_BYTES  (LINE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_extract (
        .line   (ext_line),
        .offset (ext_off),
        .size   (ext_size),
        .data   (ext_data)
    );

    // ------------------------------------------------------------ classification
    logic req_fire;
    logic live;
    logic hit_line;
    logic stream_wc;
    logic reread;
    logic serve_hit;

    always_comb begin
        req_fire  = req_valid && (r_q.state == ST_IDLE);
        live      = r_q.buf_valid && !flush;
        hit_line  = live && (dec_tag == r_q.buf_tag);
        stream_wc = (req_kind == K_STREAM) && req_wc;
        reread    = |(r_q.buf_mask & dec_cmask);
        serve_hit = hit_line && stream_wc && !reread && !dec_mis;
    end

    // ------------------------------------------------------------ next state
    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_fault = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_fire) begin
                    if (dec_mis) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_fault = 1'b1;
                        r_d.rsp_data  = '0;
                    end else if (serve_hit) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_data  = ext_data;
                        r_d.buf_mask  = r_q.buf_mask | dec_cmask;
                    end else begin
                        // Any other access that touches the buffered line discards it.
                        if (hit_line) begin
                            r_d.buf_valid = 1'b0;
                            r_d.buf_mask  = '0;
                        end
                        r_d.cur_tag   = dec_tag;
                        r_d.cur_we    = (req_kind == K_WRITE);
                        r_d.cur_wdata = req_wdata << {dec_off, 3'b000};
                        r_d.cur_be    = (req_kind == K_WRITE) ? dec_bmask : '0;
                        r_d.cur_alloc = stream_wc;
                        r_d.cur_off   = dec_off;
                        r_d.cur_size  = req_size;
                        r_d.cur_mask  = dec_cmask;
                        r_d.state     = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    r_d.state     = ST_IDLE;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = r_q.cur_we ? '0 : ext_data;
                    if (r_q.cur_alloc) begin
                        r_d.buf_valid = 1'b1;
                        r_d.buf_tag   = r_q.cur_tag;
                        r_d.buf_data  = mem_rdata;
                        r_d.buf_mask  = r_q.cur_mask;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        // A flush wins over everything, including a fill landing this cycle.
        if (flush) begin
            r_d.buf_valid = 1'b0;
            r_d.buf_mask  = '0;
            r_d.cur_alloc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // ------------------------------------------------------------ outputs
    assign req_ready     = (r_q.state == ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_ISSUE);
    assign mem_addr      = {r_q.cur_tag, {OFF_W{1'b0}}};
    assign mem_we        = r_q.cur_we;
    assign mem_wdata     = r_q.cur_wdata;
    assign mem_be        = r_q.cur_be;
    assign rsp_valid     = r_q.rsp_valid;
    assign rsp_fault     = r_q.rsp_fault;
    assign rsp_data      = r_q.rsp_data;

    // ------------------------------------------------------------ assertions
    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_data == '0)); // R8

    AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && dec_mis) |=> (rsp_fault && !mem_req_valid)); // R8

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && serve_hit) |=> (rsp_valid && !rsp_fault && !mem_req_valid)); // R3

    AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !r_q.buf_valid); // R10

endmodule

// File: tb/sllb_line_buf_tb.sv
`timescale 1ns/1ps
module sllb_line_buf_tb;

    localparam int AW = 32;
    localparam int LB = 64;
    localparam int LW = LB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [1:0]    req_kind = '0;
    logic          req_wc = 1'b0;
    logic [LW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_fault;
    logic [LW-1:0] rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [LW-1:0] mem_wdata;
    logic [LB-1:0] mem_be;
    logic          mem_rvalid = 1'b0;
    logic [LW-1:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int mem_cnt = 0;
    logic rdy_tog = 1'b0;
    logic busy = 1'b0;
    int   cd = 0;
    logic [AW-1:0] last_addr = '0;
    logic          last_we = 1'b0;
    logic [LW-1:0] last_wdata = '0;
    logic [LB-1:0] last_be = '0;
    logic stall_bad;

    always #2 clk = ~clk;

    sllb_line_buf u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_kind(req_kind), .req_wc(req_wc), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [LW-1:0] line_pat(input logic [AW-1:0] a);
        logic [LW-1:0] v;
        for (int i = 0; i < LB; i++) v[i*8 +: 8] = a[13:6] + 8'(i * 3) + 8'h5A;
        return v;
    endfunction

    function automatic logic [LW-1:0] exp_data(input logic [AW-1:0] a, input logic [1:0] sz);
        logic [LW-1:0] v;
        int n;
        v = line_pat({a[AW-1:6], 6'b0}) >> (a[5:0] * 8);
        n = 16 << sz;
        for (int i = 0; i < LB; i++) if (i >= n) v[i*8 +: 8] = 8'h00;
        return v;
    endfunction

    // Memory model: accepts on alternate cycles, answers a few cycles later.
    assign mem_req_ready = rdy_tog;
    always @(posedge clk) begin
        rdy_tog <= ~rdy_tog;
        mem_rvalid <= 1'b0;
        if (busy) begin
            if (cd == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= line_pat(last_addr);
                busy <= 1'b0;
            end else begin
                cd <= cd - 1;
            end
        end else if (mem_req_valid && mem_req_ready) begin
            busy       <= 1'b1;
            cd         <= 2;
            mem_cnt    <= mem_cnt + 1;
            last_addr  <= mem_addr;
            last_we    <= mem_we;
            last_wdata <= mem_wdata;
            last_be    <= mem_be;
        end
    end

    task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] kind, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic wc, input logic [LW-1:0] wd, input bit flush_mid,
                          output logic flt, output logic [LW-1:0] dat, output int lat, output int dm);
        int c0;
        int guard;
        guard = 0;
        @(negedge clk);
        while (!req_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        c0 = mem_cnt;
        req_valid = 1'b1; req_kind = kind; req_size = sz; req_addr = a;
        req_wc = wc; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        stall_bad = 1'b0;
        while (!rsp_valid && lat < 1000) begin
            if (req_ready) stall_bad = 1'b1;
            flush = (flush_mid && lat == 1);
            @(negedge clk);
            lat++;
        end
        flush = 1'b0;
        flt = rsp_fault;
        dat = rsp_data;
        dm  = mem_cnt - c0;
        if (!rsp_valid) begin
            checks++; fails++;
            $display("FAIL R11 no response act=0 exp=1");
        end
    endtask

    logic f;
    logic [LW-1:0] d;
    int lat, dm;

    task automatic t_reset();
        chk("R1 req_ready", LW'(req_ready), LW'(1));
        chk("R1 rsp_valid", LW'(rsp_valid), LW'(0));
        chk("R1 mem_req_valid", LW'(mem_req_valid), LW'(0));
    endtask

    task automatic t_stream_fill();
        do_req(2'd1, 2'd0, 32'h1010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R2 fill count", LW'(dm), LW'(1));
        chk("R2 line addr", LW'(last_addr), LW'(32'h1000));
        chk("R2 data", d, exp_data(32'h1010, 2'd0));
        chk("R2 fault", LW'(f), LW'(0));
    endtask

    task automatic t_buffer_hits();
        do_req(2'd1, 2'd0, 32'h1000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R3 hit16 mem", LW'(dm), LW'(0));
        chk("R3 hit16 latency", LW'(lat), LW'(1));
        chk("R3 hit16 data", d, exp_data(32'h1000, 2'd0));
        do_req(2'd1, 2'd1, 32'h1020, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R3 hit32 mem", LW'(dm), LW'(0));
        chk("R9 hit32 data", d, exp_data(32'h1020, 2'd1));
    endtask

    task automatic t_reread();
        do_req(2'd1, 2'd0, 32'h1010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R4 reread fetch", LW'(dm), LW'(1));
        chk("R4 reread data", d, exp_data(32'h1010, 2'd0));
        do_req(2'd1, 2'd0, 32'h1000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R4 fresh mask hit", LW'(dm), LW'(0));
    endtask

    task automatic t_normal_load();
        do_req(2'd0, 2'd0, 32'h1020, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R5 load via mem", LW'(dm), LW'(1));
        chk("R5 load data", d, exp_data(32'h1020, 2'd0));
        do_req(2'd1, 2'd0, 32'h1030, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R5 buffer discarded", LW'(dm), LW'(1));
    endtask

    task automatic t_nonwc();
        do_req(2'd1, 2'd0, 32'h1000, 1'b0, '0, 1'b0, f, d, lat, dm);
        chk("R6 nonwc via mem", LW'(dm), LW'(1));
        chk("R6 nonwc data", d, exp_data(32'h1000, 2'd0));
        do_req(2'd1, 2'd0, 32'h1010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R6 buffer discarded", LW'(dm), LW'(1));
        do_req(2'd1, 2'd0, 32'h7000, 1'b0, '0, 1'b0, f, d, lat, dm);
        do_req(2'd1, 2'd0, 32'h7010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R6 nonwc no allocate", LW'(dm), LW'(1));
    endtask

    task automatic t_write();
        logic [LW-1:0] wd;
        do_req(2'd1, 2'd0, 32'h1000, 1'b1, '0, 1'b0, f, d, lat, dm);
        wd = LW'(128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654);
        do_req(2'd2, 2'd0, 32'h1020, 1'b1, wd, 1'b0, f, d, lat, dm);
        chk("R7 write mem", LW'(dm), LW'(1));
        chk("R7 write we", LW'(last_we), LW'(1));
        chk("R7 write addr", LW'(last_addr), LW'(32'h1000));
        chk("R7 write be", LW'(last_be), LW'(64'h0000_FFFF_0000_0000));
        chk("R7 write data", last_wdata, wd << 256);
        do_req(2'd1, 2'd0, 32'h1010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R7 buffer discarded", LW'(dm), LW'(1));
    endtask

    task automatic t_align();
        do_req(2'd1, 2'd0, 32'h1008, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R8 fault16", LW'(f), LW'(1));
        chk("R8 fault16 data", d, '0);
        chk("R8 fault16 mem", LW'(dm), LW'(0));
        do_req(2'd1, 2'd1, 32'h1010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R8 fault32", LW'(f), LW'(1));
        do_req(2'd0, 2'd2, 32'h1020, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R8 fault64", LW'(f), LW'(1));
        do_req(2'd1, 2'd3, 32'h1000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R9 size3 fault", LW'(f), LW'(1));
        do_req(2'd1, 2'd0, 32'h1000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R8 buffer kept", LW'(dm), LW'(0));
        chk("R8 buffer data", d, exp_data(32'h1000, 2'd0));
    endtask

    task automatic t_wide();
        do_req(2'd1, 2'd2, 32'h2000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R9 fill64", LW'(dm), LW'(1));
        chk("R9 data64", d, exp_data(32'h2000, 2'd2));
        do_req(2'd1, 2'd0, 32'h2030, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R9 after64 reread", LW'(dm), LW'(1));
        do_req(2'd1, 2'd1, 32'h2000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R9 hit32 low", LW'(dm), LW'(0));
        do_req(2'd1, 2'd0, 32'h2020, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R9 hit16", LW'(dm), LW'(0));
        do_req(2'd1, 2'd1, 32'h2020, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R9 wide overlap refetch", LW'(dm), LW'(1));
    endtask

    task automatic t_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        do_req(2'd1, 2'd0, 32'h2000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R10 idle flush", LW'(dm), LW'(1));
        do_req(2'd1, 2'd0, 32'h3000, 1'b1, '0, 1'b1, f, d, lat, dm);
        chk("R10 flush mid data", d, exp_data(32'h3000, 2'd0));
        do_req(2'd1, 2'd0, 32'h3010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R10 flush mid no keep", LW'(dm), LW'(1));
    endtask

    task automatic t_stall();
        do_req(2'd1, 2'd0, 32'h4000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R11 ready low while busy", LW'(stall_bad), LW'(0));
        chk("R11 one transaction", LW'(dm), LW'(1));
    endtask

    task automatic t_other_line();
        do_req(2'd0, 2'd0, 32'h5000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R12 other load data", d, exp_data(32'h5000, 2'd0));
        do_req(2'd2, 2'd0, 32'h6000, 1'b1, '1, 1'b0, f, d, lat, dm);
        do_req(2'd1, 2'd0, 32'h5010, 1'b0, '0, 1'b0, f, d, lat, dm);
        do_req(2'd1, 2'd0, 32'h4010, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R12 buffer kept", LW'(dm), LW'(0));
        chk("R12 buffer data", d, exp_data(32'h4010, 2'd0));
        do_req(2'd1, 2'd0, 32'h4000, 1'b1, '0, 1'b0, f, d, lat, dm);
        chk("R12 mask kept", LW'(dm), LW'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream_fill();
        t_buffer_hits();
        t_reread();
        t_normal_load();
        t_nonwc();
        t_write();
        t_align();
        t_wide();
        t_flush();
        t_stall();
        t_other_line();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule